// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a physical address once the translation cache has missed. A request carries a 42-bit virtual address. The walker splits the 30-bit page-number part into three 10-bit index fields. It then follows a three-deep tree of 4 KB tables in memory, reading one 32-bit entry per level through a read port whose latency varies. The walk starts at the table page named by a base-register input, and each valid entry names the page of the next table. The final entry supplies the 18-bit physical page number.

If an entry has its valid bit clear, the walk stops at that level and reports a fault with no translation. A successful walk returns the physical page number and the full 30-bit physical address, which is that page number joined with the unchanged 12-bit offset. The walker takes one walk at a time and holds a single memory read outstanding.

Control is a five-state machine:
- **IDLE** waits for a request. It moves to ISSUE when it accepts one.
- **ISSUE** drives the read request for one cycle and always moves to WAIT.
- **WAIT** holds until read data returns. An invalid entry takes it to MISS. A valid entry at the last level takes it to HIT. A valid entry at any other level takes it back to ISSUE, one level deeper.
- **HIT** and **MISS** each raise the done output for one cycle, then return to IDLE.

Top module: `tree_xlate_walker`

## Requirements
- R1: Out of reset the walker is idle: `req_ready` is 1, and `done`, `fault` and `mem_rd_req` are 0.
- R2: The first read of a walk goes to the address formed by joining the base page number sampled at acceptance, index bits [41:32] of the address, and two zero bits. This is the base times 4096 plus the index times 4.
- R3: The second and third reads use index bits [31:22] and [21:12] respectively. Each is placed in the table page named by the entry read just before it, in the same way as R2.
- R4: A table entry is 32 bits. Bit 0 is the valid flag, and bits [29:12] hold a page number: the next table's page for the first two levels, and the physical page number at the last level. The other bits are ignored.
- R5: A clear valid bit at any level ends the walk with `done` and `fault` both 1, and with `ppn_out` and `pa_out` at 0. No further read is issued for that walk.
- R6: A walk in which all three entries are valid makes exactly three reads. It ends with `done` at 1 and `fault` at 0, `ppn_out` equal to the last entry's page number, and `pa_out` equal to that page number joined with address bits [11:0].
- R7: `done` is high for exactly one cycle per walk, and `req_ready` is 1 in the cycle after it.
- R8: A `req_valid` raised while a walk is in progress is ignored. It causes no read and no extra completion, and the current walk's result is unchanged.
- R9: `mem_rd_req` is a one-cycle pulse, and no new read is requested before the data of the previous read has returned.
- R10: Changing `base_ppn` after a request has been accepted has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request strobe, taken only when `req_ready` is 1 |
| req_va | input | 42 | Virtual address to translate |
| req_ready | output | 1 | Walker is idle and will accept a request |
| base_ppn | input | 18 | Page number of the top-level table (base register) |
| mem_rd_req | output | 1 | One-cycle read request to table memory |
| mem_rd_addr | output | 30 | Byte address of the table entry to read |
| mem_rd_valid | input | 1 | Read data is present on `mem_rd_data` |
| mem_rd_data | input | 32 | Table entry returned by memory |
| done | output | 1 | Walk finished (one-cycle pulse) |
| fault | output | 1 | Valid with `done`: the walk met an invalid entry |
| ppn_out | output | 18 | Translated physical page number, valid with `done` when no fault |
| pa_out | output | 30 | Translated physical address, valid with `done` when no fault |

## Verification
The assertions assume that memory answers each read request with exactly one `mem_rd_valid` pulse, and never raises it when no read is outstanding. They also assume that requests arrive only through the `req_valid`/`req_ready` handshake. The bench memory model keeps to both: it starts a countdown only on a request pulse, returns data once after 0 to 3 extra cycles, and checks every read address against the addresses its own software walk predicted. Stimulus covers extreme index values, faults at each of the three levels, a change of base, requests raised while busy, and a base input that is scrambled after every acceptance.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ISSUE,
        WS_WAIT,
        WS_HIT,
        WS_MISS
    } walk_state_e;

endpackage

// File: rtl/walk_idx_sel.sv
// Picks the index field that belongs to the current tree level.
module walk_idx_sel #(
    parameter int IDX_W  = 10,
    parameter int LEVELS = 3,
    localparam int VPN_W = IDX_W * LEVELS,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] field [LEVELS];

    // level 0 takes the most significant field
    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign field[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (lvl == LVL_W'(l)) begin
                idx = field[l];
            end
        end
    end

endmodule

// File: rtl/walk_entry_decode.sv
// Splits a table entry into its valid flag and page-number field.
module walk_entry_decode #(
    parameter int ENT_W = 32,
    parameter int PPN_W = 18,
    parameter int OFS_W = 12
) (
    input  logic [ENT_W-1:0] ent,
    output logic             ent_valid,
    output logic [PPN_W-1:0] ent_ppn
);

    assign ent_valid = ent[0];
    assign ent_ppn   = ent[OFS_W +: PPN_W];

    logic unused_low_bits;
    assign unused_low_bits = ^ent[OFS_W-1:1];

    if (ENT_W > PPN_W + OFS_W) begin : g_high
        logic unused_high_bits;
        assign unused_high_bits = ^ent[ENT_W-1:PPN_W+OFS_W];
    end

endmodule

// File: rtl/tree_xlate_walker.sv
module tree_xlate_walker
    import walk_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int LEVELS = 3,
    parameter int OFS_W  = 12,
    parameter int PPN_W  = 18,
    parameter int ENT_W  = 32,
    localparam int VPN_W   = IDX_W * LEVELS,
    localparam int VA_W    = VPN_W + OFS_W,
    localparam int PA_W    = PPN_W + OFS_W,
    localparam int SLOT_LG = OFS_W - IDX_W,
    localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    input  logic [PPN_W-1:0] base_ppn,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [ENT_W-1:0] mem_rd_data,
    output logic             done,
    output logic             fault,
    output logic [PPN_W-1:0] ppn_out,
    output logic [PA_W-1:0]  pa_out
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    walk_state_e      state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] tbl_ppn_q;
    logic [LVL_W-1:0] lvl_q;

    logic [IDX_W-1:0] cur_idx;
    logic             ent_valid;
    logic [PPN_W-1:0] ent_ppn;

    walk_idx_sel #(
        .IDX_W  (IDX_W),
        .LEVELS (LEVELS)
    ) u_idx_sel (
        .vpn (va_q[VA_W-1:OFS_W]),
        .lvl (lvl_q),
        .idx (cur_idx)
    );

    walk_entry_decode #(
        .ENT_W (ENT_W),
        .PPN_W (PPN_W),
        .OFS_W (OFS_W)
    ) u_entry_decode (
        .ent       (mem_rd_data),
        .ent_valid (ent_valid),
        .ent_ppn   (ent_ppn)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (req_valid) state_d = WS_ISSUE;
            WS_ISSUE: state_d = WS_WAIT;
            WS_WAIT: begin
                if (mem_rd_valid) begin
                    if (!ent_valid)             state_d = WS_MISS;
                    else if (lvl_q == LAST_LVL) state_d = WS_HIT;
                    else                        state_d = WS_ISSUE;
                end
            end
            WS_HIT:   state_d = WS_IDLE;
            WS_MISS:  state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    // state register and walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= WS_IDLE;
            va_q      <= '0;
            tbl_ppn_q <= '0;
            lvl_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WS_IDLE && req_valid) begin
                va_q      <= req_va;
                tbl_ppn_q <= base_ppn;
                lvl_q     <= '0;
            end else if (state_q == WS_WAIT && mem_rd_valid && ent_valid) begin
                tbl_ppn_q <= ent_ppn;
                if (lvl_q != LAST_LVL) begin
                    lvl_q <= lvl_q + LVL_W'(1);
                end
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready   = 1'b0;
        mem_rd_req  = 1'b0;
        done        = 1'b0;
        fault       = 1'b0;
        ppn_out     = '0;
        pa_out      = '0;
        mem_rd_addr = {tbl_ppn_q, cur_idx, {SLOT_LG{1'b0}}};
        unique case (state_q)
            WS_IDLE:  req_ready  = 1'b1;
            WS_ISSUE: mem_rd_req = 1'b1;
            WS_WAIT:  ;
            WS_HIT: begin
                done    = 1'b1;
                ppn_out = tbl_ppn_q;
                pa_out  = {tbl_ppn_q, va_q[OFS_W-1:0]};
            end
            WS_MISS: begin
                done  = 1'b1;
                fault = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/walker_chk.sv
module walker_chk #(
    parameter int OFS_W = 12,
    parameter int PPN_W = 18,
    parameter int PA_W  = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFS_W-1:0] req_ofs,
    input logic             mem_rd_req,
    input logic             mem_rd_valid,
    input logic             done,
    input logic             fault,
    input logic [PPN_W-1:0] ppn_out,
    input logic [PA_W-1:0]  pa_out
);

    logic             pending;
    logic [OFS_W-1:0] ofs_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            ofs_cap <= '0;
        end else begin
            if (mem_rd_req)        pending <= 1'b1;
            else if (mem_rd_valid) pending <= 1'b0;
            if (req_valid && req_ready) ofs_cap <= req_ofs;
        end
    end

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !pending);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    // R5
    fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && ppn_out == '0 && pa_out == '0));

    // R6
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> (pa_out[OFS_W-1:0] == ofs_cap));

    // R2
    accept_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_req);

    // R8
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !req_ready);

endmodule

bind tree_xlate_walker walker_chk #(
    .OFS_W (OFS_W),
    .PPN_W (PPN_W),
    .PA_W  (PA_W)
) u_walker_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_ofs      (req_va[OFS_W-1:0]),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .done         (done),
    .fault        (fault),
    .ppn_out      (ppn_out),
    .pa_out       (pa_out)
);

// File: tb/test_tree_xlate_walker.sv
module test_tree_xlate_walker;

    localparam int VA_W  = 42;
    localparam int PPN_W = 18;
    localparam int PA_W  = 30;

    typedef struct {
        bit              flt;
        bit [PPN_W-1:0]  ppn;
        bit [PA_W-1:0]   pa;
        int              nrd;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [VA_W-1:0]  req_va = '0;
    logic             req_ready;
    logic [PPN_W-1:0] base_ppn = '0;
    logic             mem_rd_req;
    logic [PA_W-1:0]  mem_rd_addr;
    logic             mem_rd_valid = 1'b0;
    logic [31:0]      mem_rd_data = '0;
    logic             done;
    logic             fault;
    logic [PPN_W-1:0] ppn_out;
    logic [PA_W-1:0]  pa_out;

    always #2 clk = ~clk;

    tree_xlate_walker i_tree_xlate_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_va       (req_va),
        .req_ready    (req_ready),
        .base_ppn     (base_ppn),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .done         (done),
        .fault        (fault),
        .ppn_out      (ppn_out),
        .pa_out       (pa_out)
    );

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 0;

    bit [31:0]     tbl [int];
    bit [PA_W-1:0] addr_q [$];
    exp_t          exp_q [$];
    int            rd_seen  = 0;
    int            rd_total = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic bit [31:0] mkent(input bit [PPN_W-1:0] p, input bit v);
        return {2'b00, p, 11'h000, v};
    endfunction

    function automatic bit [PA_W-1:0] slot(input bit [PPN_W-1:0] t, input bit [9:0] idx);
        return {t, idx, 2'b00};
    endfunction

    function automatic bit [31:0] lookup(input bit [PA_W-1:0] a);
        return tbl.exists(int'(a)) ? tbl[int'(a)] : 32'h0;
    endfunction

    task automatic map3(input bit [PPN_W-1:0] base, input bit [VA_W-1:0] va,
                        input bit [PPN_W-1:0] t1, input bit [PPN_W-1:0] t2,
                        input bit [PPN_W-1:0] leaf);
        tbl[int'(slot(base, va[41:32]))] = mkent(t1, 1'b1);
        tbl[int'(slot(t1,   va[31:22]))] = mkent(t2, 1'b1);
        tbl[int'(slot(t2,   va[21:12]))] = mkent(leaf, 1'b1);
    endtask

    // memory model: one read at a time, 0..3 extra cycles of latency (R9)
    bit       mbusy = 0;
    int       mcnt  = 0;
    bit [PA_W-1:0] maddr;
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (rst_n) begin
            if (mbusy) begin
                if (mcnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = lookup(maddr);
                    mbusy = 0;
                end else begin
                    mcnt--;
                end
            end
            if (mem_rd_req) begin
                check(!mbusy, "R9 read issued while one outstanding", 1, 0);
                if (addr_q.size() == 0) begin
                    check(0, "R8 unexpected read", 64'(mem_rd_addr), 0);
                end else begin
                    bit [PA_W-1:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_rd_addr == ea, "R2/R3 read address", 64'(mem_rd_addr), 64'(ea));
                end
                maddr = mem_rd_addr;
                mcnt  = rd_total % 4;
                mbusy = 1;
                rd_total++;
                rd_seen++;
            end
        end
    end

    // monitor: pops expected results as the walker completes
    bit prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                check(!done, "R7 done longer than one cycle", 64'(done), 0);
                check(req_ready, "R7 ready after done", 64'(req_ready), 1);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 extra completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(fault == e.flt, "R5/R6 fault flag", 64'(fault), 64'(e.flt));
                    check(ppn_out == e.ppn, "R5/R6 ppn_out", 64'(ppn_out), 64'(e.ppn));
                    check(pa_out == e.pa, "R5/R6 pa_out", 64'(pa_out), 64'(e.pa));
                    check(rd_seen == e.nrd, "R5/R6 read count", 64'(rd_seen), 64'(e.nrd));
                end
            end
            prev_done = done;
        end
    end

    // driver: software walk for the expected values, then the request
    task automatic walk(input bit [PPN_W-1:0] base, input bit [VA_W-1:0] va,
                        input bit poke_busy);
        exp_t e;
        bit [PPN_W-1:0] p;
        p = base;
        e.flt = 0;
        e.nrd = 0;
        for (int l = 0; l < 3; l++) begin
            bit [9:0]  idx;
            bit [31:0] ent;
            idx = va[(2-l)*10 + 12 +: 10];
            addr_q.push_back(slot(p, idx));
            ent = lookup(slot(p, idx));
            e.nrd++;
            if (!ent[0]) begin
                e.flt = 1;
                break;
            end
            p = ent[29:12];
        end
        e.ppn = e.flt ? '0 : p;
        e.pa  = e.flt ? '0 : {p, va[11:0]};
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        rd_seen   = 0;
        base_ppn  = base;
        req_va    = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        base_ppn  = ~base;          // R10: scrambled after acceptance
        req_va    = ~va;
        if (poke_busy) begin
            @(negedge clk);
            req_va    = va ^ 42'h155_5555_5000;   // R8: request while busy
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    localparam bit [PPN_W-1:0] B0 = 18'h00010;
    localparam bit [PPN_W-1:0] B1 = 18'h0002F;
    localparam bit [VA_W-1:0] VA1 = {10'd1,   10'd2,   10'd3,   12'hABC};
    localparam bit [VA_W-1:0] VA2 = {10'd1,   10'd2,   10'd4,   12'h001};
    localparam bit [VA_W-1:0] VA3 = {10'd0,   10'd0,   10'd0,   12'h000};
    localparam bit [VA_W-1:0] VA4 = {10'h3FF, 10'h3FF, 10'h3FF, 12'hFFF};
    localparam bit [VA_W-1:0] VA5 = {10'd5,   10'd6,   10'd7,   12'h444};
    localparam bit [VA_W-1:0] VA6 = {10'd6,   10'd7,   10'd8,   12'h123};
    localparam bit [VA_W-1:0] VA7 = {10'd9,   10'd10,  10'd11,  12'h321};

    initial begin
        map3(B0, VA1, 18'h00100, 18'h00200, 18'h2A5C3);
        map3(B0, VA2, 18'h00100, 18'h00200, 18'h00777);
        map3(B0, VA3, 18'h00101, 18'h00201, 18'h3FFFF);
        map3(B0, VA4, 18'h00102, 18'h00202, 18'h00001);
        map3(B0, VA6, 18'h00103, 18'h00203, 18'h00999);
        tbl[int'(slot(18'h00103, VA6[31:22]))] = mkent(18'h00203, 1'b0);  // level-2 invalid
        map3(B0, VA7, 18'h00104, 18'h00204, 18'h00155);
        tbl[int'(slot(18'h00204, VA7[21:12]))] = mkent(18'h00155, 1'b0);  // leaf invalid
        map3(B1, VA1, 18'h00110, 18'h00210, 18'h01357);

        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 req_ready in reset", 64'(req_ready), 1);
        check(done == 1'b0 && fault == 1'b0, "R1 done/fault in reset", 64'({done, fault}), 0);
        check(mem_rd_req == 1'b0, "R1 mem_rd_req in reset", 64'(mem_rd_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !done && !mem_rd_req, "R1 idle after reset",
              64'({req_ready, done, mem_rd_req}), 64'(3'b100));

        for (int pass = 0; pass < 2; pass++) begin
            walk(B0, VA1, 0);      // R6 full walk
            walk(B0, VA2, 0);      // R3 shared upper tables
            walk(B0, VA3, 0);      // R2 index 0 everywhere
            walk(B0, VA4, 0);      // R2/R3 index 1023 everywhere
            walk(B0, VA5, 0);      // R5 fault at level 1
            walk(B0, VA6, 0);      // R5 fault at level 2
            walk(B0, VA7, 0);      // R5/R4 fault at level 3
            walk(B1, VA1, 0);      // R2 other base
            walk(B0, VA1, 1);      // R8 request while busy
            walk(B1, VA2, 1);      // R5 missing branch under other base
        end

        while (!req_ready || exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
        check(addr_q.size() == 0, "R6 all predicted reads made", 64'(addr_q.size()), 0);
        check(exp_q.size() == 0, "R7 all walks completed", 64'(exp_q.size()), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule